// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a load/store unit and a simple word-wide memory bus. It keeps recently used data lines so that repeated loads and stores to the same neighbourhood are served without a bus transaction. It is direct-mapped. Each line carries a valid bit, a dirty bit and a tag. Stores that hit only update the line and mark it dirty. Memory sees the data later, when the line is evicted. On a miss with a dirty victim, all words of the victim line are written to memory before the new line is read in, one word at a time.

The CPU side uses one request at a time. The requester holds `cpuReq` and its fields steady until `cpuReady` pulses for one cycle. Accesses may be a byte, a halfword or a word, and each must sit on its natural boundary. A load narrower than a word is returned zero-extended or sign-extended, as selected by `cpuUns`. A misaligned request is answered at once with an error and changes nothing. When the line-count parameter `NUM_LINES` is zero, no storage is built and every request becomes exactly one bus transaction.

Top module: `dcache_wb`

## Requirements
- R1: While reset is held and on the first cycle after it, `cpuReady`, `cpuErr` and `memReq` are low.
- R2: Size code 0 is a byte, 1 is a halfword and 2 is a word. A byte load returns byte `addr[1:0]`, with bits 7:0 of the word being byte 0. A halfword load returns the half chosen by `addr[1]`. If `cpuUns` is 1 the value is zero-extended, otherwise it is sign-extended.
- R3: A store changes only the bytes it covers. A byte store writes lane `addr[1:0]` from `cpuWdata[7:0]`. A halfword store writes lanes `addr[1]*2` and `addr[1]*2+1` from `cpuWdata[15:0]`. A word store writes all four lanes.
- R4: A load that hits raises `cpuReady` on the first cycle after the request is taken. It causes no bus transaction.
- R5: A miss whose victim is clean or invalid issues exactly `LINE_WORDS` bus reads and no bus write. The reads cover the new line's words in ascending address order. While `memReq` waits for `memAck`, `memAddr` and `memWe` hold steady.
- R6: A miss whose victim is dirty first issues `LINE_WORDS` bus writes of the victim line at its old address, in ascending order. The refill reads follow. Memory then holds the data that was stored into the victim line.
- R7: A store that hits marks the line dirty and causes no bus transaction. Backing memory keeps its old value until the line is evicted.
- R8: A request with size code 3, or a halfword at an odd address, or a word whose `addr[1:0]` is not zero, is answered with `cpuReady` and `cpuErr` both high on the cycle after it is taken. It causes no bus transaction and changes no stored data.
- R9: With `NUM_LINES` = 0, every aligned access is exactly one bus transaction on the word holding the address. A store drives `memBe` with the byte lanes of R3. A load returns the value R2 gives from the read word.
- R10: `cpuReady` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Request valid, held until `cpuReady` |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| cpuUns | input | 1 | Zero-extend narrow loads when 1 |
| cpuAddr | input | ADDR_W | Byte address |
| cpuWdata | input | 32 | Store data, right-aligned |
| cpuRdata | output | 32 | Load result, valid with `cpuReady` |
| cpuReady | output | 1 | One-cycle completion pulse |
| cpuErr | output | 1 | Misaligned or invalid request, valid with `cpuReady` |
| memReq | output | 1 | Bus request, held until `memAck` |
| memWe | output | 1 | Bus write |
| memAddr | output | ADDR_W | Word-aligned bus address |
| memWdata | output | 32 | Bus write data |
| memBe | output | 4 | Bus byte enables |
| memRdata | input | 32 | Bus read data, valid with `memAck` |
| memAck | input | 1 | Bus transfer done |

## Verification
A wrong tag or valid bit shows up on the bus: a hit that should be silent starts a refill, or a miss returns stale data on the pulse after the request. A dirty bit that is lost or set by mistake shows in the bus log on the next eviction of that index. Either the write-back burst goes missing, which leaves stale memory, or it appears for a clean line. A wrong byte lane on a store stays hidden until a later load of that word, so the random phase reads back every address it has written, under several tags per index.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_BYP,
    ST_RESP
  } stateT;

  typedef struct packed {
    logic capture;   // latch the CPU request
    logic fillWr;    // write bus word into the line
    logic fillDone;  // last refill word: install tag
    logic storeWr;   // merge store into the line
    logic bypLatch;  // keep bus word for a direct load
    logic wbPhase;   // bus carries victim data
    logic bypPhase;  // bus carries the request itself
  } strobeT;

  function automatic logic isMisaligned(logic [1:0] sz, logic [1:0] lo);
    case (sz)
      2'd0:    return 1'b0;
      2'd1:    return lo[0];
      2'd2:    return lo != 2'b00;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] laneMask(logic [1:0] sz, logic [1:0] lo);
    case (sz)
      2'd0:    return 4'b0001 << lo;
      2'd1:    return lo[1] ? 4'b1100 : 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] laneSpread(logic [31:0] wd, logic [1:0] sz);
    case (sz)
      2'd0:    return {4{wd[7:0]}};
      2'd1:    return {2{wd[15:0]}};
      default: return wd;
    endcase
  endfunction

  function automatic logic [31:0] loadShape(logic [31:0] w, logic [1:0] sz,
                                            logic [1:0] lo, logic uns);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[{lo, 3'b000} +: 8];
    h = lo[1] ? w[31:16] : w[15:0];
    case (sz)
      2'd0:    return uns ? {24'h0, b} : {{24{b[7]}}, b};
      2'd1:    return uns ? {16'h0, h} : {{16{h[15]}}, h};
      default: return w;
    endcase
  endfunction

endpackage

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter bit BYPASS     = 1'b0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cpuReq,
  input  logic                          cpuWe,
  input  logic [1:0]                    cpuSize,
  input  logic [1:0]                    cpuAddrLo,
  input  logic                          hit,
  input  logic                          victimDirty,
  input  logic                          memAck,
  output logic                          cpuReady,
  output logic                          cpuErr,
  output logic                          memReq,
  output logic                          memWe,
  output strobeT                        strb,
  output logic [$clog2(LINE_WORDS)-1:0] wordCnt
);
  localparam int CNT_W = $clog2(LINE_WORDS);

  stateT            state, stateNx;
  logic             errQ, weQ, lastWord;
  logic [CNT_W-1:0] cntNx;

  assign lastWord = wordCnt == CNT_W'(LINE_WORDS - 1);

  always_comb begin
    stateNx  = state;
    cntNx    = wordCnt;
    strb     = '0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    cpuReady = 1'b0;
    cpuErr   = 1'b0;
    case (state)
      ST_IDLE: if (cpuReq) begin
        strb.capture = 1'b1;
        cntNx        = '0;
        if (isMisaligned(cpuSize, cpuAddrLo)) stateNx = ST_RESP;
        else if (BYPASS)                      stateNx = ST_BYP;
        else if (hit)                         stateNx = ST_RESP;
        else if (victimDirty)                 stateNx = ST_WB;
        else                                  stateNx = ST_FILL;
      end
      ST_WB: begin
        memReq       = 1'b1;
        memWe        = 1'b1;
        strb.wbPhase = 1'b1;
        if (memAck) begin
          cntNx = lastWord ? '0 : wordCnt + CNT_W'(1);
          if (lastWord) stateNx = ST_FILL;
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.fillWr = 1'b1;
          cntNx       = lastWord ? '0 : wordCnt + CNT_W'(1);
          if (lastWord) begin
            strb.fillDone = 1'b1;
            stateNx       = ST_RESP;
          end
        end
      end
      ST_BYP: begin
        memReq        = 1'b1;
        memWe         = weQ;
        strb.bypPhase = 1'b1;
        if (memAck) begin
          strb.bypLatch = 1'b1;
          stateNx       = ST_RESP;
        end
      end
      ST_RESP: begin
        cpuReady     = 1'b1;
        cpuErr       = errQ;
        strb.storeWr = weQ && !errQ && !BYPASS;
        stateNx      = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
      errQ    <= 1'b0;
      weQ     <= 1'b0;
    end else begin
      state   <= stateNx;
      wordCnt <= cntNx;
      if (strb.capture) begin
        errQ <= isMisaligned(cpuSize, cpuAddrLo);
        weQ  <= cpuWe;
      end
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cpuReady |=> !cpuReady);

  // R8: an error answer follows a cycle with no bus activity
  a_r8_err_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> $past(!memReq));

  // R6: the last write-back word hands over to a refill from word zero
  a_r6_wb_then_fill: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WB && memAck && lastWord) |=> (state == ST_FILL && wordCnt == '0));

endmodule

// File: rtl/dcache_dpath.sv
module dcache_dpath
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  strobeT                        strb,
  input  logic [$clog2(LINE_WORDS)-1:0] wordCnt,
  input  logic [ADDR_W-1:0]             cpuAddr,
  input  logic [1:0]                    cpuSize,
  input  logic                          cpuUns,
  input  logic [31:0]                   cpuWdata,
  input  logic [31:0]                   memRdata,
  output logic                          hit,
  output logic                          victimDirty,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [31:0]                   memWdata,
  output logic [3:0]                    memBe,
  output logic [31:0]                   cpuRdata
);
  localparam int  OFF_W     = $clog2(LINE_WORDS);
  localparam int  LINES_EFF = (NUM_LINES < 2) ? 2 : NUM_LINES;
  localparam int  IDX_W     = $clog2(LINES_EFF);
  localparam int  TAG_W     = ADDR_W - IDX_W - OFF_W - 2;
  localparam bit  BYPASS    = NUM_LINES == 0;

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sizeQ;
  logic              unsQ;
  logic [31:0]       wdataQ, bypWordQ;
  logic [IDX_W-1:0]  qIdx;
  logic [TAG_W-1:0]  qTag, victimTag;
  logic [OFF_W-1:0]  qWord;
  logic [3:0]        reqBe;
  logic [31:0]       reqData, victimWord, lineWord, respWord;

  assign qIdx    = addrQ[2+OFF_W +: IDX_W];
  assign qTag    = addrQ[ADDR_W-1 -: TAG_W];
  assign qWord   = addrQ[2 +: OFF_W];
  assign reqBe   = laneMask(sizeQ, addrQ[1:0]);
  assign reqData = laneSpread(wdataQ, sizeQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      sizeQ    <= '0;
      unsQ     <= 1'b0;
      wdataQ   <= '0;
      bypWordQ <= '0;
    end else begin
      if (strb.capture) begin
        addrQ  <= cpuAddr;
        sizeQ  <= cpuSize;
        unsQ   <= cpuUns;
        wdataQ <= cpuWdata;
      end
      if (strb.bypLatch) bypWordQ <= memRdata;
    end
  end

  assign memAddr  = strb.bypPhase ? {addrQ[ADDR_W-1:2], 2'b00}
                                  : {(strb.wbPhase ? victimTag : qTag), qIdx, wordCnt, 2'b00};
  assign memWdata = strb.wbPhase ? victimWord : reqData;
  assign memBe    = strb.wbPhase ? 4'hF : reqBe;
  assign respWord = BYPASS ? bypWordQ : lineWord;
  assign cpuRdata = loadShape(respWord, sizeQ, addrQ[1:0], unsQ);

  generate
    if (BYPASS) begin : g_direct
      assign hit         = 1'b0;
      assign victimDirty = 1'b0;
      assign victimTag   = '0;
      assign victimWord  = '0;
      assign lineWord    = '0;
      logic unusedDirect;
      assign unusedDirect = ^{strb.fillWr, strb.fillDone, strb.storeWr};
    end else begin : g_store
      logic [31:0]      dataArr [LINES_EFF*LINE_WORDS];
      logic [TAG_W-1:0] tagArr  [LINES_EFF];
      logic [LINES_EFF-1:0] validArr, dirtyArr;
      logic [IDX_W-1:0] liveIdx;
      logic [TAG_W-1:0] liveTag;
      logic [31:0]      storeWord;

      assign liveIdx     = cpuAddr[2+OFF_W +: IDX_W];
      assign liveTag     = cpuAddr[ADDR_W-1 -: TAG_W];
      assign hit         = validArr[liveIdx] && (tagArr[liveIdx] == liveTag);
      assign victimDirty = validArr[liveIdx] && dirtyArr[liveIdx];
      assign victimTag   = tagArr[qIdx];
      assign victimWord  = dataArr[{qIdx, wordCnt}];
      assign lineWord    = dataArr[{qIdx, qWord}];

      always_comb begin
        for (int k = 0; k < 4; k++)
          storeWord[8*k +: 8] = reqBe[k] ? reqData[8*k +: 8] : lineWord[8*k +: 8];
      end

      always_ff @(posedge clk) begin
        if (strb.fillWr)       dataArr[{qIdx, wordCnt}] <= memRdata;
        else if (strb.storeWr) dataArr[{qIdx, qWord}]   <= storeWord;
        if (strb.fillDone)     tagArr[qIdx]             <= qTag;
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          validArr <= '0;
          dirtyArr <= '0;
        end else begin
          if (strb.fillDone) begin
            validArr[qIdx] <= 1'b1;
            dirtyArr[qIdx] <= 1'b0;
          end
          if (strb.storeWr) dirtyArr[qIdx] <= 1'b1;
        end
      end

      // R7: a merged store leaves its line marked dirty
      a_r7_store_dirties: assert property (@(posedge clk) disable iff (!rstN)
        strb.storeWr |=> dirtyArr[qIdx]);
    end
  endgenerate

endmodule

// File: rtl/dcache_wb.sv
module dcache_wb
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWe,
  input  logic [1:0]        cpuSize,
  input  logic              cpuUns,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuReady,
  output logic              cpuErr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic [31:0]       memRdata,
  input  logic              memAck
);
  localparam int CNT_W  = $clog2(LINE_WORDS);
  localparam bit BYPASS = NUM_LINES == 0;

  strobeT           strb;
  logic [CNT_W-1:0] wordCnt;
  logic             hit, victimDirty;

  dcache_ctrl #(.LINE_WORDS(LINE_WORDS), .BYPASS(BYPASS)) u_ctrl (
    .clk, .rstN, .cpuReq, .cpuWe, .cpuSize,
    .cpuAddrLo(cpuAddr[1:0]),
    .hit, .victimDirty, .memAck,
    .cpuReady, .cpuErr, .memReq, .memWe, .strb, .wordCnt
  );

  dcache_dpath #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)) u_dpath (
    .clk, .rstN, .strb, .wordCnt, .cpuAddr, .cpuSize, .cpuUns, .cpuWdata,
    .memRdata, .hit, .victimDirty, .memAddr, .memWdata, .memBe, .cpuRdata
  );

  // R5: a pending bus request keeps its address and direction
  a_r5_bus_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

endmodule

// File: tb/dcache_wb_bench.sv
module dcache_wb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int LW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // cached instance signals
  logic cReq = 0, cWe = 0, cUns = 0;
  logic [1:0] cSize = 0;
  logic [AW-1:0] cAddr = 0;
  logic [31:0] cWd = 0, cRd, cMemWd, cMemRd;
  logic cReady, cErr, cMemReq, cMemWe, cAck;
  logic [AW-1:0] cMemAddr;
  logic [3:0] cMemBe;
  // direct instance signals
  logic bReq = 0, bWe = 0, bUns = 0;
  logic [1:0] bSize = 0;
  logic [AW-1:0] bAddr = 0;
  logic [31:0] bWd = 0, bRd, bMemWd, bMemRd;
  logic bReady, bErr, bMemReq, bMemWe, bAck;
  logic [AW-1:0] bMemAddr;
  logic [3:0] bMemBe;

  dcache_wb #(.ADDR_W(AW), .LINE_WORDS(LW), .NUM_LINES(8)) u_dcache_wb (
    .clk, .rstN, .cpuReq(cReq), .cpuWe(cWe), .cpuSize(cSize), .cpuUns(cUns),
    .cpuAddr(cAddr), .cpuWdata(cWd), .cpuRdata(cRd), .cpuReady(cReady), .cpuErr(cErr),
    .memReq(cMemReq), .memWe(cMemWe), .memAddr(cMemAddr), .memWdata(cMemWd),
    .memBe(cMemBe), .memRdata(cMemRd), .memAck(cAck));

  dcache_wb #(.ADDR_W(AW), .LINE_WORDS(LW), .NUM_LINES(0)) u_dcache_wb_byp (
    .clk, .rstN, .cpuReq(bReq), .cpuWe(bWe), .cpuSize(bSize), .cpuUns(bUns),
    .cpuAddr(bAddr), .cpuWdata(bWd), .cpuRdata(bRd), .cpuReady(bReady), .cpuErr(bErr),
    .memReq(bMemReq), .memWe(bMemWe), .memAddr(bMemAddr), .memWdata(bMemWd),
    .memBe(bMemBe), .memRdata(bMemRd), .memAck(bAck));

  function automatic logic [31:0] initWord(int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  // backing memories and bus logs
  logic [31:0] cMem [1024];
  logic [31:0] bMem [1024];
  int cWrN = 0, cRdN = 0, cLogN = 0, bWrN = 0, bRdN = 0, bLogN = 0;
  logic          cLogWe [64];
  logic [AW-1:0] cLogAddr [64];
  logic [3:0]    bLogBe [64];

  always @(posedge clk) begin
    if (!rstN) begin
      cAck <= 1'b0;
      for (int i = 0; i < 1024; i++) cMem[i] <= initWord(i);
    end else if (cMemReq && !cAck) begin
      if (cMemWe) begin
        for (int k = 0; k < 4; k++)
          if (cMemBe[k]) cMem[cMemAddr[AW-1:2]][8*k +: 8] <= cMemWd[8*k +: 8];
        cWrN <= cWrN + 1;
      end else begin
        cMemRd <= cMem[cMemAddr[AW-1:2]];
        cRdN   <= cRdN + 1;
      end
      cLogWe[cLogN % 64]   <= cMemWe;
      cLogAddr[cLogN % 64] <= cMemAddr;
      cLogN <= cLogN + 1;
      cAck  <= 1'b1;
    end else cAck <= 1'b0;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      bAck <= 1'b0;
      for (int i = 0; i < 1024; i++) bMem[i] <= initWord(i);
    end else if (bMemReq && !bAck) begin
      if (bMemWe) begin
        for (int k = 0; k < 4; k++)
          if (bMemBe[k]) bMem[bMemAddr[AW-1:2]][8*k +: 8] <= bMemWd[8*k +: 8];
        bWrN <= bWrN + 1;
      end else begin
        bMemRd <= bMem[bMemAddr[AW-1:2]];
        bRdN   <= bRdN + 1;
      end
      bLogBe[bLogN % 64] <= bMemBe;
      bLogN <= bLogN + 1;
      bAck  <= 1'b1;
    end else bAck <= 1'b0;
  end

  // reference models
  logic [31:0] cRef [1024];
  logic [31:0] bRef [1024];

  function automatic logic [31:0] refLoad(logic [31:0] w, logic [1:0] sz, int lo, bit uns);
    logic [31:0] s;
    s = w >> (lo * 8);
    if (sz == 2'd0) return uns ? {24'h0, s[7:0]} : {{24{s[7]}}, s[7:0]};
    if (sz == 2'd1) return uns ? {16'h0, s[15:0]} : {{16{s[15]}}, s[15:0]};
    return w;
  endfunction

  function automatic logic [31:0] refStore(logic [31:0] w, logic [1:0] sz, int lo, logic [31:0] d);
    logic [31:0] r;
    r = w;
    for (int k = 0; k < 4; k++) begin
      bit inLane;
      int off;
      inLane = (sz == 2'd2) || (sz == 2'd1 && k / 2 == lo / 2) || (sz == 2'd0 && k == lo);
      off = (sz == 2'd2) ? k : k - lo;
      if (inLane) r[8*k +: 8] = d[8*off +: 8];
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic access(input bit byp, input bit we, input logic [AW-1:0] addr,
                        input logic [1:0] sz, input bit uns, input logic [31:0] wd,
                        output logic [31:0] rd, output bit err, output int cyc);
    @(negedge clk);
    if (byp) begin bReq = 1; bWe = we; bAddr = addr; bSize = sz; bUns = uns; bWd = wd; end
    else     begin cReq = 1; cWe = we; cAddr = addr; cSize = sz; cUns = uns; cWd = wd; end
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!(byp ? bReady : cReady) && cyc < 1000);
    rd  = byp ? bRd : cRd;
    err = byp ? bErr : cErr;
    if (byp) bReq = 0; else cReq = 0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd, w;
    bit err;
    int cyc, r0, w0, l0;
    int unsigned seedV;
    seedV = $urandom(32'd7321);
    for (int i = 0; i < 1024; i++) begin cRef[i] = initWord(i); bRef[i] = initWord(i); end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!cReady && !cErr && !cMemReq, "R1 cached idle outputs in reset", {cReady, cErr, cMemReq}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!cReady && !cErr && !cMemReq, "R1 cached idle after reset", {cReady, cErr, cMemReq}, 0);
    chk(!bReady && !bErr && !bMemReq, "R1 direct idle after reset", {bReady, bErr, bMemReq}, 0);

    // R5: clean miss refills in ascending order
    r0 = cRdN; w0 = cWrN; l0 = cLogN;
    access(0, 0, 12'h040, 2'd2, 0, 0, rd, err, cyc);
    chk(rd == cRef[16], "R5 miss load value", rd, cRef[16]);
    chk(cRdN - r0 == LW && cWrN == w0, "R5 clean miss traffic", cRdN - r0, LW);
    for (int i = 0; i < LW; i++)
      chk(!cLogWe[(l0 + i) % 64] && cLogAddr[(l0 + i) % 64] == AW'(12'h040 + 4 * i),
          "R5 refill order", 32'(cLogAddr[(l0 + i) % 64]), 32'h040 + 4 * i);

    // R4: read hit in one cycle, silent bus
    r0 = cRdN;
    access(0, 0, 12'h042, 2'd1, 1, 0, rd, err, cyc);
    chk(cyc == 1, "R4 hit latency", cyc, 1);
    chk(cRdN == r0 && rd == refLoad(cRef[16], 2'd1, 2, 1), "R4 hit value and no bus", rd, refLoad(cRef[16], 2'd1, 2, 1));
    @(negedge clk);
    chk(!cReady, "R10 ready drops after one cycle", cReady, 0);

    // R3 / R2: stores and extension
    access(0, 1, 12'h050, 2'd2, 0, 32'h80F17F92, rd, err, cyc);
    cRef[20] = 32'h80F17F92;
    r0 = cRdN; w0 = cWrN;
    access(0, 1, 12'h051, 2'd0, 0, 32'h123456A5, rd, err, cyc);
    cRef[20] = refStore(cRef[20], 2'd0, 1, 32'h123456A5);
    chk(cRdN == r0 && cWrN == w0, "R7 store hit no bus", cWrN - w0, 0);
    chk(cMem[20] == initWord(20), "R7 memory untouched by store hit", cMem[20], initWord(20));
    access(0, 0, 12'h050, 2'd2, 0, 0, rd, err, cyc);
    chk(rd == 32'h80F1A592, "R3 byte lane merge", rd, 32'h80F1A592);
    access(0, 0, 12'h051, 2'd0, 0, 0, rd, err, cyc);
    chk(rd == 32'hFFFFFFA5, "R2 signed byte", rd, 32'hFFFFFFA5);
    access(0, 0, 12'h051, 2'd0, 1, 0, rd, err, cyc);
    chk(rd == 32'h000000A5, "R2 unsigned byte", rd, 32'h000000A5);
    access(0, 0, 12'h052, 2'd1, 0, 0, rd, err, cyc);
    chk(rd == 32'hFFFF80F1, "R2 signed half", rd, 32'hFFFF80F1);
    access(0, 1, 12'h056, 2'd1, 0, 32'hCAFEBEEF, rd, err, cyc);
    cRef[21] = refStore(cRef[21], 2'd1, 2, 32'hCAFEBEEF);
    access(0, 0, 12'h054, 2'd2, 0, 0, rd, err, cyc);
    chk(rd == cRef[21], "R3 upper half store", rd, cRef[21]);

    // R6: dirty eviction writes back before refill
    l0 = cLogN;
    access(0, 0, 12'h0D0, 2'd2, 0, 0, rd, err, cyc);
    chk(rd == cRef[52], "R6 load after eviction", rd, cRef[52]);
    for (int i = 0; i < LW; i++)
      chk(cLogWe[(l0 + i) % 64] && cLogAddr[(l0 + i) % 64] == AW'(12'h050 + 4 * i),
          "R6 write-back order", 32'(cLogAddr[(l0 + i) % 64]), 32'h050 + 4 * i);
    for (int i = 0; i < LW; i++)
      chk(!cLogWe[(l0 + LW + i) % 64] && cLogAddr[(l0 + LW + i) % 64] == AW'(12'h0D0 + 4 * i),
          "R6 refill after write-back", 32'(cLogAddr[(l0 + LW + i) % 64]), 32'h0D0 + 4 * i);
    chk(cMem[20] == 32'h80F1A592, "R6 victim data in memory", cMem[20], 32'h80F1A592);
    chk(cMem[21] == cRef[21], "R6 victim second word", cMem[21], cRef[21]);

    // R8: misaligned requests
    r0 = cRdN; w0 = cWrN;
    access(0, 0, 12'h0D2, 2'd2, 0, 0, rd, err, cyc);
    chk(err && cyc == 1, "R8 misaligned word", {err, 8'(cyc)}, {1'b1, 8'd1});
    access(0, 1, 12'h0D1, 2'd1, 0, 32'hFFFFFFFF, rd, err, cyc);
    chk(err, "R8 misaligned half store", err, 1);
    access(0, 1, 12'h0D0, 2'd3, 0, 32'hFFFFFFFF, rd, err, cyc);
    chk(err, "R8 size code 3", err, 1);
    chk(cRdN == r0 && cWrN == w0, "R8 no bus traffic", cRdN + cWrN, r0 + w0);
    access(0, 0, 12'h0D0, 2'd2, 0, 0, rd, err, cyc);
    chk(!err && rd == cRef[52], "R8 data unchanged", rd, cRef[52]);

    // R9: direct mode
    r0 = bRdN; w0 = bWrN;
    access(1, 0, 12'h100, 2'd2, 0, 0, rd, err, cyc);
    access(1, 0, 12'h101, 2'd0, 0, 0, rd, err, cyc);
    chk(bRdN - r0 == 2 && bWrN == w0, "R9 one read per load", bRdN - r0, 2);
    chk(rd == refLoad(bRef[64], 2'd0, 1, 0), "R9 direct byte load", rd, refLoad(bRef[64], 2'd0, 1, 0));
    l0 = bLogN;
    access(1, 1, 12'h106, 2'd1, 0, 32'h0000BEEF, rd, err, cyc);
    bRef[65] = refStore(bRef[65], 2'd1, 2, 32'h0000BEEF);
    chk(bWrN - w0 == 1 && bLogBe[l0 % 64] == 4'b1100, "R9 store lanes", 32'(bLogBe[l0 % 64]), 32'hC);
    chk(bMem[65] == bRef[65], "R9 store reaches memory", bMem[65], bRef[65]);
    access(1, 0, 12'h103, 2'd2, 0, 0, rd, err, cyc);
    chk(err, "R8 direct misaligned", err, 1);

    // random mix on both instances
    for (int n = 0; n < 600; n++) begin
      bit byp, we, uns;
      logic [1:0] sz;
      int lo, wi;
      logic [AW-1:0] a;
      logic [31:0] d, e;
      byp = n % 2;
      we  = $urandom % 2;
      uns = $urandom % 2;
      sz  = 2'($urandom % 3);
      lo  = (sz == 2'd0) ? $urandom % 4 : (sz == 2'd1) ? 2 * ($urandom % 2) : 0;
      a   = AW'(($urandom % 3) * 128 + ($urandom % 8) * 16 + ($urandom % 4) * 4 + lo);
      d   = $urandom;
      wi  = int'(a[AW-1:2]);
      access(byp, we, a, sz, uns, d, rd, err, cyc);
      if (we) begin
        if (byp) bRef[wi] = refStore(bRef[wi], sz, lo, d);
        else     cRef[wi] = refStore(cRef[wi], sz, lo, d);
        chk(!err, "R3 random store accepted", err, 0);
      end else begin
        e = refLoad(byp ? bRef[wi] : cRef[wi], sz, lo, uns);
        chk(!err && rd == e, byp ? "R9 random direct load" : "R2 random cached load", rd, e);
      end
    end
    // random store lanes reach direct memory
    for (int i = 0; i < 96; i++) begin
      w = bMem[i];
      if (w != bRef[i]) chk(0, "R9 direct memory image", w, bRef[i]);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule